// File: doc/BRIEF.md
# Branch Resolution and Program Counter Control

This block decides where instruction fetch goes next in a five-stage, in-order 32-bit integer pipeline. A conditional branch is resolved late, in the execute stage, and nothing is predicted. The block compares the two branch operands, which already come from the forwarding multiplexers. It also computes the branch target from the branch instruction's own PC and its encoded immediate, and it owns the fetch program counter register.

When no branch is taken, fetch advances by one 32-bit instruction each cycle. A stall request holds the PC where it is. When a valid branch in execute is taken, the PC is redirected to the target. In the same cycle, the block asks for the two younger instructions to be squashed: the one held in the fetch/decode pipeline register and the one held in the decode/execute register. A taken branch wins over a stall.

Top module: `br_pc_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `fetch_pc` becomes 0x0000_0000 after that edge (synchronous, active-low reset).
- R2: With no taken branch and `stall_in` low, `fetch_pc` increases by 4 at each rising edge.
- R3: The branch target is `ex_pc` plus the 12-bit signed `ex_imm` multiplied by 2 (the immediate counts halfwords). Examples: an immediate of 4 gives +8, an immediate of -20 gives -40, an immediate of 0x800 gives -4096, and an immediate of 0x7FF gives +4094.
- R4: `ex_funct3` 000 takes the branch when the operands are equal, and 001 takes it when they differ.
- R5: `ex_funct3` 100 takes the branch when `ex_op_a` < `ex_op_b` as signed values, and 101 takes it when `ex_op_a` >= `ex_op_b` as signed values.
- R6: `ex_funct3` 110 takes the branch when `ex_op_a` < `ex_op_b` as unsigned values, and 111 takes it when `ex_op_a` >= `ex_op_b` as unsigned values.
- R7: `ex_funct3` 010 and 011 are never taken.
- R8: A taken branch raises `flush_ifid` and `flush_idex` together, combinationally in the same cycle, and the next `fetch_pc` equals the target.
- R9: With `stall_in` high and no taken branch, `fetch_pc` keeps its value.
- R10: A taken branch overrides `stall_in`: the flushes are raised and `fetch_pc` moves to the target.
- R11: With `ex_br_valid` low, no flush is raised and the operands and immediate have no effect on `fetch_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_br_valid | input | 1 | A conditional branch occupies the execute stage |
| ex_funct3 | input | 3 | Comparison selector of that branch |
| ex_op_a | input | 32 | First operand, after forwarding |
| ex_op_b | input | 32 | Second operand, after forwarding |
| ex_pc | input | 32 | PC of the branch in execute |
| ex_imm | input | 12 | Encoded branch offset in halfwords, signed |
| stall_in | input | 1 | Hold request for the fetch PC |
| fetch_pc | output | 32 | Address of the next instruction to fetch |
| flush_ifid | output | 1 | Squash the fetch/decode pipeline register |
| flush_idex | output | 1 | Squash the decode/execute pipeline register |

## Verification
On every cycle, the embedded assertions check the PC update rules: the +4 step, the hold under stall, the redirect to the registered target, and the target arithmetic. They also check that no flush is raised without a valid branch, with unequal operands under the equality code, or under the two unused codes. The choice of comparison for each code, the signed and unsigned corner values around zero and the sign bit, the immediate extremes and reset itself can only be shown by the bench. It drives these cases and compares them with values it computes on its own.

// File: rtl/br_pc_pkg.sv
// Package: shared branch condition codes for the PC control block.
// Assumes the 3-bit condition selector of the integer base instruction set.
package br_pc_pkg;
    typedef enum logic [2:0] {
        BC_EQ  = 3'b000,
        BC_NE  = 3'b001,
        BC_LT  = 3'b100,
        BC_GE  = 3'b101,
        BC_LTU = 3'b110,
        BC_GEU = 3'b111
    } br_cond_e;
endpackage

// File: rtl/br_cond_unit.sv
// Module: evaluates a conditional branch comparison in the execute stage.
// Assumes the operands are already forwarded; codes that are not used are never taken.
module br_cond_unit #(
    parameter int XLEN = 32
) (
    input  logic            valid,
    input  logic [2:0]      funct3,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            taken
);
    import br_pc_pkg::*;

    logic eq_w, lt_s_w, lt_u_w, cond_w;

    // Purpose: basic relations shared by all condition codes.
    always_comb begin
        eq_w   = (op_a == op_b);
        lt_s_w = ($signed(op_a) < $signed(op_b));
        lt_u_w = (op_a < op_b);
    end

    // Purpose: select the relation named by funct3.
    always_comb begin
        case (funct3)
            BC_EQ:   cond_w = eq_w;
            BC_NE:   cond_w = !eq_w;
            BC_LT:   cond_w = lt_s_w;
            BC_GE:   cond_w = !lt_s_w;
            BC_LTU:  cond_w = lt_u_w;
            BC_GEU:  cond_w = !lt_u_w;
            default: cond_w = 1'b0;
        endcase
        taken = valid && cond_w;
    end
endmodule

// File: rtl/br_target_gen.sv
// Module: forms the branch target from the branch PC and a halfword-scaled immediate.
// Assumes the immediate arrives encoded (without the implicit low zero bit).
module br_target_gen #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 12
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  target
);
    localparam int OFF_W = IMM_W + 1;
    localparam int EXT_W = XLEN - OFF_W;

    logic [XLEN-1:0] offset_w;

    // Purpose: sign-extend the doubled immediate and add it to the branch PC.
    always_comb begin
        offset_w = {{EXT_W{imm[IMM_W-1]}}, imm, 1'b0};
        target   = pc + offset_w;
    end
endmodule

// File: rtl/pc_seq_reg.sv
// Module: fetch program counter register with redirect, hold and step.
// Assumes redirect has priority over stall; reset is synchronous, active low.
module pc_seq_reg #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0,
    parameter int              STEP     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect,
    input  logic [XLEN-1:0] redirect_pc,
    input  logic            stall,
    output logic [XLEN-1:0] pc
);
    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    // Purpose: update the PC by reset, redirect, hold or sequential step.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc <= RESET_PC;
        else if (redirect) pc <= redirect_pc;
        else if (!stall)   pc <= pc + STEP_V;
    end

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && !stall) |=> (pc == $past(pc) + STEP_V));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !redirect) |=> $stable(pc));

    assert_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (pc == $past(redirect_pc)));
endmodule

// File: rtl/br_pc_ctrl.sv
// Module: top of branch resolution and PC control, with zero-prediction and late EX resolution.
// Assumes one conditional branch at most in execute; a taken branch squashes IF/ID and ID/EX.
module br_pc_ctrl #(
    parameter int              XLEN     = 32,
    parameter int              IMM_W    = 12,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ex_br_valid,
    input  logic [2:0]       ex_funct3,
    input  logic [XLEN-1:0]  ex_op_a,
    input  logic [XLEN-1:0]  ex_op_b,
    input  logic [XLEN-1:0]  ex_pc,
    input  logic [IMM_W-1:0] ex_imm,
    input  logic             stall_in,
    output logic [XLEN-1:0]  fetch_pc,
    output logic             flush_ifid,
    output logic             flush_idex
);
    localparam int EXT_W = XLEN - IMM_W - 1;

    logic            taken_w;
    logic [XLEN-1:0] target_w;

    br_cond_unit #(.XLEN(XLEN)) u_cond (
        .valid  (ex_br_valid),
        .funct3 (ex_funct3),
        .op_a   (ex_op_a),
        .op_b   (ex_op_b),
        .taken  (taken_w)
    );

    br_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_tgt (
        .pc     (ex_pc),
        .imm    (ex_imm),
        .target (target_w)
    );

    pc_seq_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC), .STEP(4)) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .redirect    (taken_w),
        .redirect_pc (target_w),
        .stall       (stall_in),
        .pc          (fetch_pc)
    );

    // Purpose: a taken branch squashes both younger stages, regardless of stall.
    always_comb begin
        flush_ifid = taken_w;
        flush_idex = taken_w;
    end

    assert_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_br_valid |-> !flush_ifid && !flush_idex);

    assert_eq_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_br_valid && ex_funct3 == 3'b000 && ex_op_a != ex_op_b) |-> !flush_ifid);

    assert_unused_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_br_valid && ex_funct3[2:1] == 2'b01) |-> !flush_ifid);

    assert_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ifid |=> (fetch_pc == $past(ex_pc)
                        + {{EXT_W{$past(ex_imm[IMM_W-1])}}, $past(ex_imm), 1'b0}));
endmodule

// File: tb/br_pc_ctrl_tb.sv
`timescale 1ns/1ps
module br_pc_ctrl_tb;
    typedef struct packed {
        logic        v;
        logic [2:0]  f3;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] pc;
        logic [11:0] imm;
        logic        st;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'b000, 32'd5,        32'd5,        32'h100,  12'd4,    1'b0, 1'b1, 4'd4},
        '{1'b1, 3'b000, 32'd5,        32'd6,        32'h100,  12'd4,    1'b0, 1'b0, 4'd4},
        '{1'b1, 3'b001, 32'd5,        32'd6,        32'h200,  12'hFEC,  1'b0, 1'b1, 4'd4},
        '{1'b1, 3'b001, 32'd7,        32'd7,        32'h200,  12'hFEC,  1'b0, 1'b0, 4'd4},
        '{1'b1, 3'b100, 32'hFFFFFFFF, 32'd1,        32'h300,  12'd8,    1'b0, 1'b1, 4'd5},
        '{1'b1, 3'b100, 32'd1,        32'hFFFFFFFF, 32'h300,  12'd8,    1'b0, 1'b0, 4'd5},
        '{1'b1, 3'b101, 32'd1,        32'hFFFFFFFF, 32'h340,  12'd2,    1'b0, 1'b1, 4'd5},
        '{1'b1, 3'b101, 32'd3,        32'd3,        32'h340,  12'd2,    1'b0, 1'b1, 4'd5},
        '{1'b1, 3'b101, 32'hFFFFFFFB, 32'd2,        32'h340,  12'd2,    1'b0, 1'b0, 4'd5},
        '{1'b1, 3'b110, 32'hFFFFFFFF, 32'd1,        32'h400,  12'd16,   1'b0, 1'b0, 4'd6},
        '{1'b1, 3'b110, 32'd1,        32'hFFFFFFFF, 32'h400,  12'd16,   1'b0, 1'b1, 4'd6},
        '{1'b1, 3'b111, 32'hFFFFFFFF, 32'd1,        32'h480,  12'd6,    1'b0, 1'b1, 4'd6},
        '{1'b1, 3'b111, 32'd2,        32'd3,        32'h480,  12'd6,    1'b0, 1'b0, 4'd6},
        '{1'b1, 3'b010, 32'd9,        32'd9,        32'h500,  12'd4,    1'b0, 1'b0, 4'd7},
        '{1'b1, 3'b011, 32'd1,        32'd2,        32'h500,  12'd4,    1'b0, 1'b0, 4'd7},
        '{1'b0, 3'b000, 32'd5,        32'd5,        32'h600,  12'd4,    1'b0, 1'b0, 4'd11},
        '{1'b0, 3'b000, 32'd0,        32'd0,        32'h600,  12'd4,    1'b1, 1'b0, 4'd9},
        '{1'b1, 3'b000, 32'd1,        32'd1,        32'h700,  12'd10,   1'b1, 1'b1, 4'd10},
        '{1'b1, 3'b000, 32'd1,        32'd1,        32'h1000, 12'h800,  1'b0, 1'b1, 4'd3},
        '{1'b1, 3'b001, 32'd1,        32'd0,        32'h0,    12'h7FF,  1'b0, 1'b1, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ex_br_valid;
    logic [2:0]  ex_funct3;
    logic [31:0] ex_op_a, ex_op_b, ex_pc;
    logic [11:0] ex_imm;
    logic        stall_in;
    logic [31:0] fetch_pc;
    logic        flush_ifid, flush_idex;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] model_pc;
    bit done = 0;

    always #10 clk = ~clk;

    br_pc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ex_br_valid(ex_br_valid), .ex_funct3(ex_funct3),
        .ex_op_a(ex_op_a), .ex_op_b(ex_op_b), .ex_pc(ex_pc), .ex_imm(ex_imm),
        .stall_in(stall_in), .fetch_pc(fetch_pc), .flush_ifid(flush_ifid),
        .flush_idex(flush_idex)
    );

    function automatic string req_tag(input logic [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ex_br_valid = 1'b0; ex_funct3 = 3'b000; ex_op_a = '0; ex_op_b = '0;
        ex_pc = '0; ex_imm = '0; stall_in = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset value", fetch_pc, 32'h0);
        rst_n = 1'b1;
        model_pc = 32'h0;

        // R2: plain sequential steps
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            model_pc = model_pc + 32'd4;
            check("R2 step", fetch_pc, model_pc);
        end

        // table walk: flushes same cycle, PC after the next edge
        for (int i = 0; i < NV; i++) begin
            logic [31:0] tgt;
            ex_br_valid = VECS[i].v;   ex_funct3 = VECS[i].f3;
            ex_op_a = VECS[i].a;       ex_op_b = VECS[i].b;
            ex_pc = VECS[i].pc;        ex_imm = VECS[i].imm;
            stall_in = VECS[i].st;
            tgt = VECS[i].pc + {{19{VECS[i].imm[11]}}, VECS[i].imm, 1'b0};
            #1;
            check({req_tag(VECS[i].req), " R8 flush_ifid"}, {31'b0, flush_ifid}, {31'b0, VECS[i].exp});
            check({req_tag(VECS[i].req), " R8 flush_idex"}, {31'b0, flush_idex}, {31'b0, VECS[i].exp});
            if (VECS[i].exp)      model_pc = tgt;
            else if (!VECS[i].st) model_pc = model_pc + 32'd4;
            @(posedge clk); @(negedge clk);
            check({req_tag(VECS[i].req), " next pc"}, fetch_pc, model_pc);
        end

        // R3 explicit example values, independent of the table
        idle_inputs();
        ex_br_valid = 1'b1; ex_pc = 32'h2C; ex_imm = 12'd4; ex_op_a = 32'd7; ex_funct3 = 3'b101;
        @(posedge clk); @(negedge clk);
        check("R3 imm 4 gives +8", fetch_pc, 32'h34);
        ex_pc = 32'h3C; ex_imm = 12'hFEC; ex_funct3 = 3'b100; ex_op_a = 32'd1; ex_op_b = 32'd5;
        @(posedge clk); @(negedge clk);
        check("R3 imm -20 gives -40", fetch_pc, 32'h14);

        // R9: several stalled cycles hold the PC
        idle_inputs();
        stall_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 hold over stall", fetch_pc, 32'h14);
        stall_in = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R2 resume after stall", fetch_pc, 32'h18);

        // R1: reset in mid-run overrides a taken branch
        ex_br_valid = 1'b1; ex_funct3 = 3'b000; ex_pc = 32'h800; ex_imm = 12'd2;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 reset mid-run", fetch_pc, 32'h0);
        rst_n = 1'b1;
        idle_inputs();
        @(posedge clk); @(negedge clk);
        check("R2 step after reset", fetch_pc, 32'h4);

        done = 1;
        finish_run();
    end
endmodule